// File: doc/BRIEF.md
# Serial ADC Burst Readout Controller

This block is the master side of a three-wire link to a 10-bit successive-approximation converter. The link has three wires: an active-low chip select, a serial clock and a serial data input. A start request launches a burst of conversion frames. In each frame chip select goes low, sixteen serial clock pulses are issued and the ten result bits are captured, most significant first. Chip select then returns high and stays high for at least one full conversion time before the next frame begins.

The converter always hands out the result of the conversion started by the frame before. The first frame after reset or a long pause therefore returns stale data. Only the final frame of a burst is kept. That value is presented right-aligned as a 16-bit word, and also as a byte pair: the upper byte holds result bits 9..2 and the lower byte holds bits 1..0 in its two lowest positions. A one-cycle done strobe marks the moment the value is valid. The serial clock half-period and the settle interval are cycle counts, derived by default from the system clock frequency, the highest serial clock the converter accepts and the 21 µs conversion time.

Top module: `adc_burst_reader`

## Requirements
- R1: Every frame consists of one chip-select low period containing exactly 16 rising edges of the serial clock, and the serial clock rises only while chip select is low.
- R2: The serial clock is low whenever chip select is high. Each high phase of the serial clock lasts exactly SCLK_HALF system cycles.
- R3: Chip select stays high for at least SETTLE_CYC system cycles before every falling edge. This holds for the first frame after reset and between frames.
- R4: The data input is sampled on the first 10 rising serial clock edges of a frame, in the order bit 9 down to bit 0. Data present on rising edges 11 to 16 has no effect on the result.
- R5: A start request with frame count N produces N frames, and a count of 0 produces one frame.
- R6: Only the last frame of a burst is reported. result_o changes only in the cycle in which done_o is high. A burst of one frame reports the value the converter held from the previous burst.
- R7: result_o carries the 10-bit value in bits 9..0 with zeros above. res_hi_o equals bits 9..2. res_lo_o holds bits 1..0 in its bit positions 1..0, with zeros in bits 7..2.
- R8: done_o is high for exactly one cycle, SETTLE_CYC+1 clock edges after chip select last rises. busy_o is high from the cycle after the accepted start until the done cycle, and it is low in the done cycle.
- R9: A start request while busy_o is high is ignored: the frame count of the running burst is unchanged and no extra frame follows done.
- R10: Synchronous active-high reset drives chip select high and the serial clock low, clears busy and done, clears all result outputs and aborts any burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a burst (taken only when idle) |
| frames_i | input | CNT_W | Frames per burst, 0 treated as 1 |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle result valid strobe |
| result_o | output | 16 | Right-aligned 10-bit result |
| res_hi_o | output | 8 | Result bits 9..2 |
| res_lo_o | output | 8 | Result bits 1..0 in positions 1..0 |

## Verification
Busy is due one edge after start is sampled. Each serial clock high phase is due SCLK_HALF edges after it begins. Each chip-select fall is due SETTLE_CYC+1 edges after the previous rise. Done and the new result are due SETTLE_CYC+1 edges after the last rise of chip select. The bench samples on the falling system clock edge and counts those cycles with a monitor from the observed rise of each signal. It compares each count against these exact figures, so a result that is off by one cycle is reported. A behavioural converter model shifts out the value latched at the previous chip-select fall and drives ones after bit 0. This makes a stale first frame and stray trailing bits visible in the packed outputs.

// File: rtl/adc_burst_reader.sv
module adc_burst_reader #(
  parameter int CLK_HZ     = 250_000_000,
  parameter int SCLK_HZ    = 2_000_000,
  parameter int CONV_NS    = 21_000,
  parameter int CNT_W      = 4,
  parameter int DATA_W     = 10,
  parameter int PULSES     = 16,
  parameter int SCLK_HALF  = (CLK_HZ + 2*SCLK_HZ - 1) / (2*SCLK_HZ),
  parameter int SETTLE_CYC = int'((64'(CLK_HZ) * 64'(CONV_NS) + 64'd999_999_999) / 64'd1_000_000_000)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] frames_i,
  input  logic             sdo_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [15:0]      result_o,
  output logic [7:0]       res_hi_o,
  output logic [7:0]       res_lo_o
);

  localparam int DIV_W   = $clog2(SCLK_HALF + 1);
  localparam int SET_W   = $clog2(SETTLE_CYC + 1);
  localparam int EDGE_W  = $clog2(PULSES + 1);
  localparam int LO_BITS = DATA_W - 8;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SHIFT, S_LAST} state_t;

  state_t              state;
  logic [DIV_W-1:0]    div_cnt;
  logic [EDGE_W-1:0]   edge_cnt;
  logic [SET_W-1:0]    hi_cnt;
  logic [CNT_W-1:0]    rem;
  logic [DATA_W-1:0]   shreg;
  logic [DATA_W-1:0]   res;
  logic                tick;
  logic                settled;

  assign tick     = (div_cnt == DIV_W'(SCLK_HALF - 1));
  assign settled  = (hi_cnt == SET_W'(SETTLE_CYC));
  assign busy_o   = (state != S_IDLE);
  assign result_o = {{(16-DATA_W){1'b0}}, res};
  assign res_hi_o = res[DATA_W-1 -: 8];
  assign res_lo_o = {{(8-LO_BITS){1'b0}}, res[LO_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cs_n_o   <= 1'b1;
      sclk_o   <= 1'b0;
      div_cnt  <= '0;
      edge_cnt <= '0;
      hi_cnt   <= '0;
      rem      <= '0;
      shreg    <= '0;
      res      <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!cs_n_o)      hi_cnt <= '0;
      else if (!settled) hi_cnt <= hi_cnt + 1'b1;

      case (state)
        S_IDLE: begin
          if (start_i) begin
            rem   <= (frames_i == '0) ? CNT_W'(1) : frames_i;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (settled) begin
            cs_n_o   <= 1'b0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            state    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            div_cnt <= '0;
            sclk_o  <= ~sclk_o;
            if (!sclk_o) begin
              if (edge_cnt < EDGE_W'(DATA_W))
                shreg <= {shreg[DATA_W-2:0], sdo_i};
              edge_cnt <= edge_cnt + 1'b1;
            end else if (edge_cnt == EDGE_W'(PULSES)) begin
              cs_n_o <= 1'b1;
              rem    <= rem - 1'b1;
              state  <= (rem == CNT_W'(1)) ? S_LAST : S_WAIT;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_LAST: begin
          if (settled) begin
            res    <= shreg;
            done_o <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst) cs_n_o |-> !sclk_o); // R2
  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (rst) $rose(sclk_o) |-> !cs_n_o); // R1
  AST_CS_SETTLE: assert property (@(posedge clk) disable iff (rst) $fell(cs_n_o) |-> $past(hi_cnt) == SET_W'(SETTLE_CYC)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R8
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(result_o) |-> done_o); // R6

endmodule

// File: tb/test_adc_burst_reader.sv
module test_adc_burst_reader;
  localparam int HALF   = 5;
  localparam int SETTLE = 100;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, sdo = 1'b0;
  logic [3:0] frames = '0;
  logic cs_n, sclk, busy, done;
  logic [15:0] result;
  logic [7:0] res_hi, res_lo;

  always #2 clk = ~clk;

  adc_burst_reader #(.SCLK_HALF(HALF), .SETTLE_CYC(SETTLE)) i_adc_burst_reader (
    .clk(clk), .rst(rst), .start_i(start), .frames_i(frames), .sdo_i(sdo),
    .cs_n_o(cs_n), .sclk_o(sclk), .busy_o(busy), .done_o(done),
    .result_o(result), .res_hi_o(res_hi), .res_lo_o(res_lo));

  int n_chk = 0, n_fail = 0;

  // converter model: returns the value latched at the previous frame
  logic [9:0] ain = '0, prev_conv = 10'h155, out_word = '0;
  logic tail = 1'b0;
  int bit_i = -1;
  always @(negedge cs_n) begin
    out_word = prev_conv; prev_conv = ain; bit_i = 9; sdo = out_word[9];
  end
  always @(negedge sclk) begin
    bit_i = bit_i - 1;
    sdo = (bit_i >= 0) ? out_word[bit_i] : tail;
  end

  // monitor
  int cyc = 0, falls = 0, rises = 0, hrun = 0, hi_run = 0;
  int gap_bad = 0, half_bad = 0, rise_bad = 0, idle_bad = 0, lat_bad = 0, wide_bad = 0;
  logic pcs = 1'b1, psclk = 1'b0, pdone = 1'b0;
  bit wd_hit = 0;
  always @(negedge clk) begin
    cyc++;
    if (pcs && !cs_n) begin
      falls++;
      if (!rst && hi_run < SETTLE + 1) gap_bad++;
      rises = 0;
    end
    if (!psclk && sclk) rises++;
    if (psclk && !sclk && hrun != HALF) half_bad++;
    if (sclk) hrun++; else hrun = 0;
    if (!pcs && cs_n && !rst && rises != 16) rise_bad++;
    if (cs_n) hi_run++; else hi_run = 0;
    if (done) begin
      if (hi_run != SETTLE + 2) lat_bad++;
      if (pdone) wide_bad++;
    end
    if (cs_n && sclk) idle_bad++;
    pcs = cs_n; psclk = sclk; pdone = done;
    if (cyc >= 180000 && !wd_hit) begin
      wd_hit = 1; n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<%0d", cyc, 180000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset_idle();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R10", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R10", "sclk in reset", sclk, 0);
    chk(busy == 1'b0 && done == 1'b0, "R10", "busy/done in reset", {busy, done}, 0);
    chk(result == 16'h0 && res_hi == 8'h0 && res_lo == 8'h0, "R10", "result in reset", result, 0);
    rst = 1'b0;
  endtask

  task automatic t_burst(input int n, input logic [9:0] a, input logic t, input bit extra_start);
    int f0 = falls, g0 = gap_bad, h0 = half_bad, r0 = rise_bad, i0 = idle_bad, l0 = lat_bad, w0 = wide_bad;
    int nexp = (n == 0) ? 1 : n;
    logic [9:0] exp = (nexp == 1) ? prev_conv : a;
    int w = 0, busy_drop = 0;
    logic [15:0] held;
    ain = a; tail = t; frames = 4'(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", busy, 1);
    if (extra_start) begin
      repeat (200) @(negedge clk);
      start = 1'b1; frames = 4'd15;
      @(negedge clk);
      start = 1'b0; frames = 4'(n);
    end
    while (!done && w < 40000) begin
      if (!busy) busy_drop++;
      @(negedge clk); w++;
    end
    chk(done == 1'b1, "R8", "done reached", done, 1);
    chk(busy_drop == 0 && busy == 1'b0, "R8", "busy until done", busy_drop, 0);
    chk(falls - f0 == nexp, "R5", "frame count", falls - f0, nexp);
    chk(rise_bad == r0, "R1", "16 clocks per frame", rise_bad - r0, 0);
    chk(half_bad == h0 && idle_bad == i0, "R2", "sclk shape/idle", half_bad - h0 + idle_bad - i0, 0);
    chk(gap_bad == g0, "R3", "cs high settle", gap_bad - g0, 0);
    chk(lat_bad == l0, "R8", "done latency", lat_bad - l0, 0);
    chk(result == {6'b0, exp}, "R6", "reported result (R4 sampling)", result, {6'b0, exp});
    chk(res_hi == exp[9:2], "R7", "high byte", res_hi, exp[9:2]);
    chk(res_lo == {6'b0, exp[1:0]}, "R7", "low byte", res_lo, {6'b0, exp[1:0]});
    held = result;
    f0 = falls;
    repeat (3 * SETTLE) @(negedge clk);
    chk(wide_bad == w0, "R8", "done one cycle", wide_bad - w0, 0);
    chk(falls == f0, "R9", "no frame after done", falls - f0, 0);
    chk(result == held, "R6", "result held", result, held);
  endtask

  task automatic t_reset_mid();
    ain = 10'h2AA; frames = 4'd2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    chk(cs_n == 1'b0 || busy == 1'b1, "R10", "burst running before reset", busy, 1);
    t_reset_idle();
  endtask

  initial begin
    t_reset_idle();
    t_burst(2, 10'h2C7, 1'b0, 0);   // R4 R7 main burst
    t_burst(1, 10'h0FF, 1'b0, 0);   // R6 stale single frame
    t_burst(0, 10'h3FF, 1'b1, 0);   // R5 zero count, R4 trailing ones ignored
    t_burst(3, 10'h001, 1'b1, 1);   // R9 start while busy ignored
    t_reset_mid();                  // R10 abort
    t_burst(2, 10'h155, 1'b0, 0);   // recovery after reset, R3 first frame
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule